// File: doc/BRIEF.md
# Predicated Vector Branch Element Evaluator

This block decides the outcome of one element of a vectorised conditional branch within a single cycle. It receives the branch option bits, the selected condition bit, the 64-bit count register and the element's predicate bit. It also receives the mode controls for zeroing, the result used when the predicate is false, count-test enable, count-test inversion and conditional link update. From these it produces a taken flag, the updated count value, a link-register write enable and an early-stop flag that ends the instruction. Every one of these outputs is combinational.

A registered side serves the element-loop sequencer. When the evaluate strobe `eval_i` is high, the count register copy `ctr_q_o` loads the updated count value on the clock edge, and a small outcome state machine records the result of that element. The states are ST_IDLE, ST_FALL, ST_TAKEN, ST_TAKEN_LINK and ST_STOPPED. On each edge the machine moves as follows:
- It goes to ST_IDLE when `eval_i` is low.
- It goes to ST_STOPPED when the element raised the stop flag.
- It goes to ST_TAKEN_LINK when the branch was taken with a link write.
- It goes to ST_TAKEN when the branch was taken without a link write.
- It goes to ST_FALL otherwise.

Reset returns the machine to ST_IDLE.

Top module: `brc_eval`

## Requirements
- R1: The counter nonzero test looks at all 64 bits of `ctr_i` when `wide_mode_i`=1 and at bits 31:0 only when `wide_mode_i`=0. The counter test passes when `skip_ctr_i`=1, or when (nonzero XOR `ctr_sense_i`)=1.
- R2: The condition test passes when `skip_cond_i`=1, or when `cr_bit_i` equals `cond_sense_i`.
- R3: When the stop flag is low, `taken_o` is 1 exactly when both the counter test and the condition test pass.
- R4: When `pred_i`=0, both the counter test and the condition test take the value of `pred_false_res_i`. This value also feeds the decrement decision.
- R5: The early-stop case holds when `pred_i`=0, `zero_mode_i`=0, `skip_ctr_i`=0, `ctr_test_i`=1 and `ctr_test_inv_i`=0 all at once. In that case `stop_o`=1, `ctr_next_o`=`ctr_i`-1, and `taken_o`=0 and `lr_we_o`=0. In every other case `stop_o`=0.
- R6: Outside the early-stop case, `ctr_next_o`=`ctr_i`-1 when `skip_ctr_i`=0 and not (`ctr_test_i`=1 and (condition test XOR `ctr_test_inv_i`)=1). Otherwise `ctr_next_o`=`ctr_i`.
- R7: The decrement wraps modulo 2^64, so 0 becomes all ones. Both tests use the value before the decrement. `ctr_next_o` is driven whether or not the branch is taken.
- R8: `lr_we_o` is 1 only when `link_cond_i`=1 and `taken_o`=1.
- R9: On a rising clock edge with `eval_i`=1, `ctr_q_o` loads `ctr_next_o`, and `taken_q_o`, `lr_we_q_o` and `stop_q_o` take the values of `taken_o`, `lr_we_o` and `stop_o`. With `eval_i`=0, `ctr_q_o` holds its value and the three flags go to 0.
- R10: While `rst_n` is low, `ctr_q_o` is 0 and `taken_q_o`, `lr_we_q_o` and `stop_q_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Evaluate strobe for the registered side |
| skip_cond_i | input | 1 | Ignore the condition bit (condition test passes) |
| cond_sense_i | input | 1 | Condition bit value required for the test to pass |
| skip_ctr_i | input | 1 | Ignore the counter and never decrement it |
| ctr_sense_i | input | 1 | Inverts the counter nonzero test |
| cr_bit_i | input | 1 | Selected condition-register bit |
| ctr_i | input | 64 | Current count register value |
| wide_mode_i | input | 1 | 1: 64-bit counter test, 0: low 32 bits |
| pred_i | input | 1 | Element predicate bit |
| zero_mode_i | input | 1 | Zeroing mode (prevents early stop) |
| pred_false_res_i | input | 1 | Test result used when the predicate is 0 |
| ctr_test_i | input | 1 | Count-test mode enable |
| ctr_test_inv_i | input | 1 | Count-test invert |
| link_cond_i | input | 1 | Conditional link-update enable |
| taken_o | output | 1 | Branch taken |
| ctr_next_o | output | 64 | Updated count value |
| lr_we_o | output | 1 | Link-register write enable |
| stop_o | output | 1 | Early stop, ends the instruction |
| ctr_q_o | output | 64 | Registered count value |
| taken_q_o | output | 1 | Registered taken flag |
| lr_we_q_o | output | 1 | Registered link write enable |
| stop_q_o | output | 1 | Registered stop flag |

## Verification
The clocked assertions sample the combinational outputs at the rising edge. They assume every input is settled and known at that edge and does not change around it. The bench keeps to this by changing all inputs one nanosecond after each rising edge and holding them for the rest of the period. It also keeps `eval_i` defined in every cycle, so the registered checks always see a known strobe. Where the counter arithmetic is involved, the stimulus includes zero, one, the 32-bit boundary and all-ones values, so that the wrap and the narrow-mode test are both reached.

// File: rtl/brc_pkg.sv
package brc_pkg;
    parameter int CTR_W    = 64;
    parameter int NARROW_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FALL,
        ST_TAKEN,
        ST_TAKEN_LINK,
        ST_STOPPED
    } outcome_e;

    typedef struct packed {
        logic skip_cond;
        logic cond_sense;
        logic skip_ctr;
        logic ctr_sense;
    } opt_t;

    typedef struct packed {
        logic zero_mode;
        logic pred_false_res;
        logic ctr_test;
        logic ctr_test_inv;
        logic link_cond;
    } mode_t;
endpackage

// File: rtl/brc_tests.sv
module brc_tests
    import brc_pkg::*;
#(
    parameter int W  = CTR_W,
    parameter int NW = NARROW_W
) (
    input  opt_t         opt_i,
    input  logic         cr_bit_i,
    input  logic [W-1:0] ctr_i,
    input  logic         wide_i,
    input  logic         pred_i,
    input  logic         pf_res_i,
    output logic         ctr_ok_o,
    output logic         cond_ok_o
);
    logic nz_wide;
    logic nz_narrow;
    logic nz_sel;
    logic ctr_raw;
    logic cond_raw;

    assign nz_wide = |ctr_i;

    generate
        if (NW < W) begin : g_narrow
            assign nz_narrow = |ctr_i[NW-1:0];
        end else begin : g_full
            assign nz_narrow = nz_wide;
        end
    endgenerate

    always_comb begin
        nz_sel   = wide_i ? nz_wide : nz_narrow;
        ctr_raw  = opt_i.skip_ctr  | (nz_sel ^ opt_i.ctr_sense);
        cond_raw = opt_i.skip_cond | ~(cr_bit_i ^ opt_i.cond_sense);
        if (pred_i) begin
            ctr_ok_o  = ctr_raw;
            cond_ok_o = cond_raw;
        end else begin
            ctr_ok_o  = pf_res_i;
            cond_ok_o = pf_res_i;
        end
    end
endmodule

// File: rtl/brc_count.sv
module brc_count
    import brc_pkg::*;
#(
    parameter int W = CTR_W
) (
    input  logic [W-1:0] ctr_i,
    input  logic         skip_ctr_i,
    input  logic         pred_i,
    input  mode_t        mode_i,
    input  logic         cond_ok_i,
    output logic [W-1:0] ctr_next_o,
    output logic         stop_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic hold_by_test;
    logic dec;

    always_comb begin
        stop_o       = ~pred_i & ~mode_i.zero_mode & ~skip_ctr_i
                       & mode_i.ctr_test & ~mode_i.ctr_test_inv;
        hold_by_test = mode_i.ctr_test & (cond_ok_i ^ mode_i.ctr_test_inv);
        dec          = stop_o | (~skip_ctr_i & ~hold_by_test);
        ctr_next_o   = dec ? (ctr_i - ONE) : ctr_i;
    end
endmodule

// File: rtl/brc_outcome_fsm.sv
module brc_outcome_fsm
    import brc_pkg::*;
#(
    parameter int W = CTR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         eval_i,
    input  logic         taken_i,
    input  logic         lr_we_i,
    input  logic         stop_i,
    input  logic [W-1:0] ctr_next_i,
    output logic [W-1:0] ctr_q_o,
    output logic         taken_q_o,
    output logic         lr_we_q_o,
    output logic         stop_q_o
);
    outcome_e state_q;
    outcome_e state_d;

    always_comb begin
        if (!eval_i)                state_d = ST_IDLE;
        else if (stop_i)            state_d = ST_STOPPED;
        else if (taken_i && lr_we_i) state_d = ST_TAKEN_LINK;
        else if (taken_i)           state_d = ST_TAKEN;
        else                        state_d = ST_FALL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctr_q_o <= '0;
        end else begin
            state_q <= state_d;
            if (eval_i) ctr_q_o <= ctr_next_i;
        end
    end

    always_comb begin
        taken_q_o = 1'b0;
        lr_we_q_o = 1'b0;
        stop_q_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:       ;
            ST_FALL:       ;
            ST_TAKEN:      taken_q_o = 1'b1;
            ST_TAKEN_LINK: begin
                taken_q_o = 1'b1;
                lr_we_q_o = 1'b1;
            end
            ST_STOPPED:    stop_q_o = 1'b1;
            default:       ;
        endcase
    end

    assert_ctr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i |=> ctr_q_o == $past(ctr_next_i));
    assert_ctr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> $stable(ctr_q_o));
    assert_idle_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> !taken_q_o && !lr_we_q_o && !stop_q_o);
    assert_stop_recorded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && stop_i) |=> stop_q_o && !taken_q_o);
endmodule

// File: rtl/brc_eval.sv
module brc_eval
    import brc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic              skip_cond_i,
    input  logic              cond_sense_i,
    input  logic              skip_ctr_i,
    input  logic              ctr_sense_i,
    input  logic              cr_bit_i,
    input  logic [CTR_W-1:0]  ctr_i,
    input  logic              wide_mode_i,
    input  logic              pred_i,
    input  logic              zero_mode_i,
    input  logic              pred_false_res_i,
    input  logic              ctr_test_i,
    input  logic              ctr_test_inv_i,
    input  logic              link_cond_i,
    output logic              taken_o,
    output logic [CTR_W-1:0]  ctr_next_o,
    output logic              lr_we_o,
    output logic              stop_o,
    output logic [CTR_W-1:0]  ctr_q_o,
    output logic              taken_q_o,
    output logic              lr_we_q_o,
    output logic              stop_q_o
);
    localparam logic [CTR_W-1:0] ONE = {{(CTR_W-1){1'b0}}, 1'b1};

    opt_t  opt;
    mode_t mode;
    logic  ctr_ok;
    logic  cond_ok;

    assign opt  = '{skip_cond: skip_cond_i, cond_sense: cond_sense_i,
                    skip_ctr: skip_ctr_i, ctr_sense: ctr_sense_i};
    assign mode = '{zero_mode: zero_mode_i, pred_false_res: pred_false_res_i,
                    ctr_test: ctr_test_i, ctr_test_inv: ctr_test_inv_i,
                    link_cond: link_cond_i};

    brc_tests #(.W(CTR_W), .NW(NARROW_W)) tests_i (
        .opt_i     (opt),
        .cr_bit_i  (cr_bit_i),
        .ctr_i     (ctr_i),
        .wide_i    (wide_mode_i),
        .pred_i    (pred_i),
        .pf_res_i  (pred_false_res_i),
        .ctr_ok_o  (ctr_ok),
        .cond_ok_o (cond_ok)
    );

    brc_count #(.W(CTR_W)) count_i (
        .ctr_i      (ctr_i),
        .skip_ctr_i (skip_ctr_i),
        .pred_i     (pred_i),
        .mode_i     (mode),
        .cond_ok_i  (cond_ok),
        .ctr_next_o (ctr_next_o),
        .stop_o     (stop_o)
    );

    assign taken_o = ctr_ok & cond_ok & ~stop_o;
    assign lr_we_o = taken_o & mode.link_cond;

    brc_outcome_fsm #(.W(CTR_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .eval_i     (eval_i),
        .taken_i    (taken_o),
        .lr_we_i    (lr_we_o),
        .stop_i     (stop_o),
        .ctr_next_i (ctr_next_o),
        .ctr_q_o    (ctr_q_o),
        .taken_q_o  (taken_q_o),
        .lr_we_q_o  (lr_we_q_o),
        .stop_q_o   (stop_q_o)
    );

    assert_stop_no_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !taken_o && !lr_we_o && ctr_next_o == ctr_i - ONE);
    assert_link_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we_o |-> link_cond_i && taken_o);
    assert_pred_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_i && !stop_o) |-> taken_o == pred_false_res_i);
    assert_skip_ctr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_ctr_i |-> ctr_next_o == ctr_i && !stop_o);
endmodule

// File: tb/brc_eval_tb_top.sv
module brc_eval_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval_i = 1'b0;
    logic        skip_cond_i = 1'b0, cond_sense_i = 1'b0, skip_ctr_i = 1'b0, ctr_sense_i = 1'b0;
    logic        cr_bit_i = 1'b0;
    logic [63:0] ctr_i = '0;
    logic        wide_mode_i = 1'b0, pred_i = 1'b1;
    logic        zero_mode_i = 1'b0, pred_false_res_i = 1'b0, ctr_test_i = 1'b0;
    logic        ctr_test_inv_i = 1'b0, link_cond_i = 1'b0;
    logic        taken_o, lr_we_o, stop_o, taken_q_o, lr_we_q_o, stop_q_o;
    logic [63:0] ctr_next_o, ctr_q_o;

    always #2 clk = ~clk;

    brc_eval dut_i (.*);

    typedef struct {
        logic        taken;
        logic        lr;
        logic        stop;
        logic [63:0] nxt;
        logic        ev;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    mon_on = 0;
    bit    done = 0;

    logic [63:0] e_ctr_q = '0;
    logic        e_tk_q = 0, e_lr_q = 0, e_st_q = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected outcome from the requirements
    function automatic item_t model(input logic [3:0] opt, input logic cr,
                                    input logic [63:0] ctr, input logic wide,
                                    input logic pred, input logic [4:0] md,
                                    input logic ev, input string tag);
        item_t r;
        logic nz, c_ok, k_ok, stp, dec;
        nz   = wide ? (ctr != 0) : (ctr[31:0] != 0);
        c_ok = opt[1] | (nz ^ opt[0]);
        k_ok = opt[3] | (cr == opt[2]);
        if (!pred) begin
            c_ok = md[3];
            k_ok = md[3];
        end
        stp = !pred && !md[4] && !opt[1] && md[2] && !md[1];
        dec = stp || (!opt[1] && !(md[2] && (k_ok ^ md[1])));
        r.nxt   = dec ? ctr - 64'd1 : ctr;
        r.stop  = stp;
        r.taken = !stp && c_ok && k_ok;
        r.lr    = r.taken && md[0];
        r.ev    = ev;
        r.tag   = tag;
        return r;
    endfunction

    // opt = {skip_cond, cond_sense, skip_ctr, ctr_sense}
    // md  = {zero_mode, pred_false_res, ctr_test, ctr_test_inv, link_cond}
    task automatic step(input logic [3:0] opt, input logic cr, input logic [63:0] ctr,
                        input logic wide, input logic pred, input logic [4:0] md,
                        input logic ev, input string tag);
        @(posedge clk);
        #1;
        {skip_cond_i, cond_sense_i, skip_ctr_i, ctr_sense_i} = opt;
        cr_bit_i = cr; ctr_i = ctr; wide_mode_i = wide; pred_i = pred;
        {zero_mode_i, pred_false_res_i, ctr_test_i, ctr_test_inv_i, link_cond_i} = md;
        eval_i = ev;
        q.push_back(model(opt, cr, ctr, wide, pred, md, ev, tag));
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (mon_on) begin
                chk("R9", "ctr_q", ctr_q_o, e_ctr_q);
                chk("R9", "taken_q", {63'd0, taken_q_o}, {63'd0, e_tk_q});
                chk("R9", "lr_we_q", {63'd0, lr_we_q_o}, {63'd0, e_lr_q});
                chk("R9", "stop_q", {63'd0, stop_q_o}, {63'd0, e_st_q});
                if (q.size() > 0) begin
                    item_t it;
                    it = q.pop_front();
                    chk(it.tag, "taken", {63'd0, taken_o}, {63'd0, it.taken});
                    chk(it.tag, "lr_we", {63'd0, lr_we_o}, {63'd0, it.lr});
                    chk(it.tag, "stop", {63'd0, stop_o}, {63'd0, it.stop});
                    chk(it.tag, "ctr_next", ctr_next_o, it.nxt);
                    if (it.ev) begin
                        e_ctr_q = it.nxt;
                        e_tk_q = it.taken; e_lr_q = it.lr; e_st_q = it.stop;
                    end else begin
                        e_tk_q = 0; e_lr_q = 0; e_st_q = 0;
                    end
                end else begin
                    e_tk_q = 0; e_lr_q = 0; e_st_q = 0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        chk("R10", "ctr_q reset", ctr_q_o, 64'd0);
        chk("R10", "flags reset", {61'd0, taken_q_o, lr_we_q_o, stop_q_o}, 64'd0);
        rst_n = 1'b1;
        mon_on = 1;

        // R1: wide versus narrow nonzero test, bit 32 only set
        step(4'b1000, 0, 64'h1_0000_0000, 1, 1, 5'b00000, 1, "R1");
        step(4'b1000, 0, 64'h1_0000_0000, 0, 1, 5'b00000, 1, "R1");
        step(4'b1001, 0, 64'h1_0000_0000, 0, 1, 5'b00000, 1, "R1");
        step(4'b1010, 0, 64'd0, 1, 1, 5'b00000, 1, "R1");
        // R2: condition bit match / mismatch / skip
        step(4'b0110, 1, 64'd5, 1, 1, 5'b00000, 1, "R2");
        step(4'b0110, 0, 64'd5, 1, 1, 5'b00000, 1, "R2");
        step(4'b0010, 0, 64'd5, 1, 1, 5'b00000, 1, "R2");
        step(4'b1110, 0, 64'd5, 1, 1, 5'b00000, 1, "R2");
        // R3: both pass, one fails
        step(4'b0100, 1, 64'd7, 1, 1, 5'b00000, 1, "R3");
        step(4'b0101, 1, 64'd7, 1, 1, 5'b00000, 1, "R3");
        // R4: predicate false overrides both tests
        step(4'b0101, 0, 64'd0, 1, 0, 5'b01000, 1, "R4");
        step(4'b1010, 1, 64'd3, 1, 0, 5'b00000, 1, "R4");
        step(4'b1000, 0, 64'd3, 1, 0, 5'b11101, 1, "R4");
        // R5: early stop
        step(4'b1000, 0, 64'd9, 1, 0, 5'b01101, 1, "R5");
        step(4'b1000, 0, 64'd0, 0, 0, 5'b00101, 1, "R5");
        step(4'b1000, 0, 64'd9, 1, 0, 5'b10101, 1, "R5");
        step(4'b1000, 0, 64'd9, 1, 0, 5'b00111, 1, "R5");
        // R6: count-test suppression of the decrement
        step(4'b1000, 0, 64'd4, 1, 1, 5'b00100, 1, "R6");
        step(4'b0000, 1, 64'd4, 1, 1, 5'b00100, 1, "R6");
        step(4'b0000, 1, 64'd4, 1, 1, 5'b00110, 1, "R6");
        step(4'b1010, 0, 64'd4, 1, 1, 5'b00000, 1, "R6");
        // R7: wrap and pre-decrement testing
        step(4'b1000, 0, 64'd0, 1, 1, 5'b00000, 1, "R7");
        step(4'b1000, 0, 64'd1, 1, 1, 5'b00000, 1, "R7");
        step(4'b1000, 0, 64'h1_0000_0000, 0, 1, 5'b00000, 1, "R7");
        step(4'b0100, 0, 64'd1, 1, 1, 5'b00000, 1, "R7");
        // R8: link gating
        step(4'b1000, 0, 64'd2, 1, 1, 5'b00001, 1, "R8");
        step(4'b1000, 0, 64'd2, 1, 1, 5'b00000, 1, "R8");
        step(4'b0100, 0, 64'd2, 1, 1, 5'b00001, 1, "R8");
        // R9: strobe low holds the registered count
        step(4'b1000, 0, 64'd77, 1, 1, 5'b00001, 0, "R9");
        step(4'b1000, 0, 64'd78, 1, 1, 5'b00001, 0, "R9");
        step(4'b1000, 0, 64'd79, 1, 1, 5'b00001, 1, "R9");

        // R3: mixed patterns
        for (int i = 0; i < 400; i++) begin
            logic [63:0] c;
            c = {$urandom(), $urandom()};
            if (i % 4 == 0) c = {$urandom() & 32'h3, 32'd0};
            if (i % 4 == 1) c = 64'($urandom() & 3);
            step(4'($urandom()), 1'($urandom()), c, 1'($urandom()), 1'($urandom()),
                 5'($urandom()), 1'($urandom()), "R3");
        end

        step(4'b0000, 0, 64'd0, 1, 1, 5'b00000, 0, "R9");
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule